// File: doc/BRIEF.md
# Arc-Tangent Argument Range Reducer

This block sits in front of a single-precision arc-tangent core that is only accurate for arguments of magnitude at most one. Each FP32 operand that arrives is sorted into one of three ranges by comparing its magnitude bits against the encoding of 1.0. The sign then decides the range, so no floating-point comparator is needed. Operands already inside the core's range go to the core unchanged. Operands outside it go with a flag that tells the core to evaluate the arc tangent of the reciprocal. The block then folds a ±pi/2 offset into the returned value.

Not-a-number, infinity and zero inputs are resolved locally and never reach the core. A tag queue carries, for every accepted operand, its offset choice or its locally made answer. Because of this queue, the core may take any number of cycles per request, and results still leave in the order the operands came in. Handshakes are valid/ready on the operand input, on the core request, on the core response and on the result output.

The offset step always subtracts a magnitude of at most pi/4 from pi/2. It therefore cannot cancel leading bits, and it needs only a one-position normalisation.

Top module: `atan_range_reducer`

## Requirements
- R1: After reset, outValid and coreReqValid are low, and inReady is high for a zero operand.
- R2: A NaN operand (exponent all ones, fraction non-zero) returns the same bits with fraction bit 22 set. It issues no core request.
- R3: +infinity returns 0x3FC90FDB and -infinity returns 0xBFC90FDB, with no core request.
- R4: +0 and -0 return themselves with the sign kept, with no core request.
- R5: An operand with magnitude below 1.0 (0x3F800000 on bits 30:0), or exactly +1.0, is sent to the core as-is with coreReqRecip low. The core result is output bit for bit.
- R6: A positive operand with magnitude above 1.0 is sent with coreReqRecip high. The output is pi/2 (0x3FC90FDB) minus the core result, rounded to nearest-even.
- R7: A negative operand with magnitude of 1.0 or more is sent with coreReqRecip high. The output is -pi/2 plus the magnitude of the core result (that is, -pi/2 minus the core result), rounded to nearest-even.
- R8: Results appear in operand order whatever the core latency and however locally resolved operands are interleaved. A result offered while outReady is low stays offered.
- R9: At most DEPTH operands are in flight. With DEPTH results unconsumed, inReady is low.
- R10: Outputs for non-special operands lie within 4 ULP of the true arc tangent. They are non-decreasing as the operand increases through -1.0 and through +1.0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand offered |
| inReady | output | 1 | Operand accepted this cycle when high with inValid |
| inX | input | 32 | FP32 operand |
| coreReqValid | output | 1 | Request to the arc-tangent core |
| coreReqReady | input | 1 | Core takes the request |
| coreReqArg | output | 32 | Argument for the core |
| coreReqRecip | output | 1 | Core must evaluate atan(1/arg) |
| coreRspValid | input | 1 | Core result available, held until taken |
| coreRspReady | output | 1 | Block takes the core result |
| coreRspData | input | 32 | FP32 core result |
| outValid | output | 1 | Final angle offered |
| outReady | input | 1 | Consumer takes the angle |
| outAngle | output | 32 | FP32 arc tangent of the operand |

## Verification
The hardest case to reach is a full tag queue whose head waits on a slow core response, while locally resolved results queue up behind it and a new special operand is already presented. Only at that point do ordering and back-pressure interact. The bench models the core with a random per-request delay and a randomly withheld request ready. It throttles outReady at random and mixes specials into long random runs. For one phase it also blocks the output completely, fills the queue with specials and then probes inReady. Boundary sweeps of single-ULP steps across ±1.0 exercise the switch between the direct and reduced paths.

// File: rtl/atanr_pkg.sv
package atanr_pkg;

  // Offset applied to the core result once it returns.
  typedef enum logic [1:0] {
    OFS_NONE = 2'd0,
    OFS_NEG  = 2'd1,
    OFS_POS  = 2'd2
  } ofs_e;

  // One entry of the in-order tag queue.
  typedef struct packed {
    logic        bypass;   // answer already known, core not involved
    ofs_e        ofs;      // offset choice for core results
    logic [31:0] val;      // local answer when bypass is set
  } tag_t;

  // Classifier verdict for the operand at the input.
  typedef struct packed {
    logic special;
    logic recip;
    tag_t tag;
  } cls_t;

  // Strobes from control to datapath and queue.
  typedef struct packed {
    logic push;
    logic pop;
    logic useBypass;
    logic useAdder;
  } strobe_t;

  localparam logic [31:0] HALF_PI_F32    = 32'h3FC90FDB;
  localparam logic [31:0] QUARTER_PI_F32 = 32'h3F490FDB;
  localparam logic [31:0] ONE_F32        = 32'h3F800000;
  localparam logic [31:0] QUIET_BIT      = 32'h00400000;

endpackage

// File: rtl/atanr_tagq.sv
module atanr_tagq
  import atanr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic push,
  input  tag_t pushTag,
  input  logic pop,
  output tag_t headTag,
  output logic empty,
  output logic full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  tag_t          mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  assign empty   = (count == '0);
  assign full    = (count == FULL_CNT);
  assign headTag = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushTag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: never accept more than DEPTH operands in flight
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    push |-> !full);

  // R8: a result only leaves when an operand was queued for it
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

  // R9: occupancy stays within the configured depth
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

endmodule

// File: rtl/atanr_ctrl.sv
module atanr_ctrl
  import atanr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    clsSpecial,
  input  logic    coreReqReady,
  input  logic    coreRspValid,
  input  logic    outReady,
  input  logic    qEmpty,
  input  logic    qFull,
  input  logic    headBypass,
  input  ofs_e    headOfs,
  output logic    inReady,
  output logic    coreReqValid,
  output logic    coreRspReady,
  output logic    outValid,
  output strobe_t strobe
);

  logic headWaitsCore;

  always_comb begin
    // Specials need only a queue slot; others also need the core.
    inReady       = !qFull && (clsSpecial || coreReqReady);
    coreReqValid  = inValid && !clsSpecial && !qFull;
    headWaitsCore = !qEmpty && !headBypass;
    outValid      = !qEmpty && (headBypass || coreRspValid);
    coreRspReady  = headWaitsCore && outReady;

    strobe.push      = inValid && inReady;
    strobe.pop       = outValid && outReady;
    strobe.useBypass = headBypass;
    strobe.useAdder  = (headOfs != OFS_NONE);
  end

  // R8: an offered result is not withdrawn before it is taken
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  // R8: a core response always has a queued operand to match
  p_rsp_has_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    coreRspValid |-> !qEmpty);

endmodule

// File: rtl/atanr_dp.sv
module atanr_dp
  import atanr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] inX,
  input  logic [31:0] coreRspData,
  input  logic        coreRspValid,
  input  logic [31:0] headVal,
  input  ofs_e        headOfs,
  input  strobe_t     strobe,
  output cls_t        cls,
  output logic [31:0] outAngle
);

  localparam int MANT_W  = 24;                 // significand with hidden bit
  localparam int EXT_W   = MANT_W + 3;         // plus guard, round, sticky
  localparam int WIDE_W  = 2 * MANT_W + 2;     // alignment window
  localparam int SHIFT_W = $clog2(WIDE_W + 1);
  localparam logic [7:0] HALF_PI_EXP = HALF_PI_F32[30:23];

  // ---------------- operand classifier ----------------
  logic       xSign, isNan, isInf, isZero, magGe1, magGt1;
  logic [7:0] xExp;

  always_comb begin
    xSign  = inX[31];
    xExp   = inX[30:23];
    isNan  = (&xExp) && (|inX[22:0]);
    isInf  = (&xExp) && !(|inX[22:0]);
    isZero = !(|inX[30:0]);
    magGe1 = inX[30:0] >= ONE_F32[30:0];
    magGt1 = inX[30:0] >  ONE_F32[30:0];

    cls         = '0;
    cls.tag.ofs = OFS_NONE;
    if (isNan) begin
      cls.special    = 1'b1;
      cls.tag.bypass = 1'b1;
      cls.tag.val    = inX | QUIET_BIT;
    end else if (isInf) begin
      cls.special    = 1'b1;
      cls.tag.bypass = 1'b1;
      cls.tag.val    = {xSign, HALF_PI_F32[30:0]};
    end else if (isZero) begin
      cls.special    = 1'b1;
      cls.tag.bypass = 1'b1;
      cls.tag.val    = inX;
    end else begin
      if (xSign && magGe1)       cls.tag.ofs = OFS_NEG;
      else if (!xSign && magGt1) cls.tag.ofs = OFS_POS;
      cls.recip = (cls.tag.ofs != OFS_NONE);
    end
  end

  // ---------------- offset adder: sign*pi/2 - coreRspData ----------------
  logic               resSign, subOp;
  logic [7:0]         rExp, rExpEff, shiftAmt;
  logic [SHIFT_W-1:0] shiftC;
  logic [MANT_W-1:0]  ma, mb;
  logic [WIDE_W-1:0]  wide;
  logic [EXT_W-1:0]   maExt, mbAl, nrm;
  logic [EXT_W:0]     sumRaw;
  logic [7:0]         expBase, expOut;
  logic               roundUp;
  logic [MANT_W:0]    mantR;
  logic [22:0]        fracOut;
  logic [31:0]        sumOut;

  always_comb begin
    resSign = (headOfs == OFS_NEG);
    // The core result enters negated, so the op is a subtraction
    // whenever its negated sign differs from the offset's sign.
    subOp   = (!coreRspData[31]) ^ resSign;

    rExp    = coreRspData[30:23];
    rExpEff = (rExp == 8'd0) ? 8'd1 : rExp;
    ma      = {1'b1, HALF_PI_F32[22:0]};
    mb      = {(rExp != 8'd0), coreRspData[22:0]};

    shiftAmt = (rExpEff >= HALF_PI_EXP) ? 8'd0 : (HALF_PI_EXP - rExpEff);
    shiftC   = (shiftAmt > 8'(WIDE_W)) ? SHIFT_W'(WIDE_W) : shiftAmt[SHIFT_W-1:0];
    wide     = {mb, {(WIDE_W - MANT_W){1'b0}}} >> shiftC;
    mbAl     = {wide[WIDE_W-1 -: (MANT_W + 2)], |wide[WIDE_W-MANT_W-3:0]};
    maExt    = {ma, 3'b000};

    sumRaw = subOp ? ({1'b0, maExt} - {1'b0, mbAl})
                   : ({1'b0, maExt} + {1'b0, mbAl});

    if (sumRaw[EXT_W]) begin
      nrm     = {sumRaw[EXT_W:2], sumRaw[1] | sumRaw[0]};
      expBase = HALF_PI_EXP + 8'd1;
    end else if (sumRaw[EXT_W-1]) begin
      nrm     = sumRaw[EXT_W-1:0];
      expBase = HALF_PI_EXP;
    end else begin
      nrm     = {sumRaw[EXT_W-2:0], 1'b0};
      expBase = HALF_PI_EXP - 8'd1;
    end

    roundUp = nrm[2] && (nrm[1] || nrm[0] || nrm[3]);
    mantR   = {1'b0, nrm[EXT_W-1:3]} + {{MANT_W{1'b0}}, roundUp};
    fracOut = mantR[MANT_W] ? mantR[23:1] : mantR[22:0];
    expOut  = expBase + {7'd0, mantR[MANT_W]};
    sumOut  = {resSign, expOut, fracOut};
  end

  always_comb begin
    if (strobe.useBypass)     outAngle = headVal;
    else if (strobe.useAdder) outAngle = sumOut;
    else                      outAngle = coreRspData;
  end

  // R6: a reduced argument yields a core result within pi/4
  p_core_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (coreRspValid && !strobe.useBypass && strobe.useAdder)
      |-> (coreRspData[30:0] <= QUARTER_PI_F32[30:0]));

  // R7: the offset step keeps its leading bits (no cancellation)
  p_no_cancel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (coreRspValid && !strobe.useBypass && strobe.useAdder)
      |-> (sumRaw[EXT_W:EXT_W-2] != 3'b000));

endmodule

// File: rtl/atan_range_reducer.sv
module atan_range_reducer
  import atanr_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic [31:0] inX,
  output logic        coreReqValid,
  input  logic        coreReqReady,
  output logic [31:0] coreReqArg,
  output logic        coreReqRecip,
  input  logic        coreRspValid,
  output logic        coreRspReady,
  input  logic [31:0] coreRspData,
  output logic        outValid,
  input  logic        outReady,
  output logic [31:0] outAngle
);

  cls_t    cls;
  strobe_t strobe;
  tag_t    headTag;
  logic    qEmpty, qFull;

  assign coreReqArg   = inX;
  assign coreReqRecip = cls.recip;

  atanr_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inX         (inX),
    .coreRspData (coreRspData),
    .coreRspValid(coreRspValid),
    .headVal     (headTag.val),
    .headOfs     (headTag.ofs),
    .strobe      (strobe),
    .cls         (cls),
    .outAngle    (outAngle)
  );

  atanr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .clsSpecial  (cls.special),
    .coreReqReady(coreReqReady),
    .coreRspValid(coreRspValid),
    .outReady    (outReady),
    .qEmpty      (qEmpty),
    .qFull       (qFull),
    .headBypass  (headTag.bypass),
    .headOfs     (headTag.ofs),
    .inReady     (inReady),
    .coreReqValid(coreReqValid),
    .coreRspReady(coreRspReady),
    .outValid    (outValid),
    .strobe      (strobe)
  );

  atanr_tagq #(.DEPTH(DEPTH)) u_tagq (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobe.push),
    .pushTag(cls.tag),
    .pop    (strobe.pop),
    .headTag(headTag),
    .empty  (qEmpty),
    .full   (qFull)
  );

endmodule

// File: tb/atan_range_reducer_tb.sv
`timescale 1ns/1ps
module atan_range_reducer_tb;

  localparam int DEPTH = 4;
  localparam int TOL_ULP = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inX = 32'h0;
  logic        coreReqValid;
  logic        coreReqReady = 1'b0;
  logic [31:0] coreReqArg;
  logic        coreReqRecip;
  logic        coreRspValid = 1'b0;
  logic        coreRspReady;
  logic [31:0] coreRspData = 32'h0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outAngle;

  always #4 clk = ~clk;   // 125 MHz

  atan_range_reducer #(.DEPTH(DEPTH)) u_dut (.*);

  int checks = 0;
  int failures = 0;

  // scoreboard queues
  logic [31:0] expVal[$];
  bit          expExact[$];
  string       expTag[$];
  logic [31:0] reqArgQ[$];
  bit          reqRecipQ[$];
  string       reqTagQ[$];
  logic [31:0] coreRes[$];
  int          coreDly[$];
  logic [31:0] monoLog[$];
  bit          monoOn = 1'b0;
  bit          holdOut = 1'b0;

  function automatic real fromF32(input logic [31:0] b);
    logic [63:0] d;
    if (b[30:23] == 8'd0)
      return (b[31] ? -1.0 : 1.0) * real'(b[22:0]) * (2.0 ** -149);
    d = {b[31], 11'(int'(b[30:23]) + 896), b[22:0], 29'd0};
    return $bitstoreal(d);
  endfunction

  function automatic logic [31:0] toF32(input real v);
    logic [63:0] d;
    int          e;
    logic [23:0] m;
    d = $realtobits(v);
    e = int'(d[62:52]) - 1023 + 127;
    if (d[62:0] == 63'd0 || e <= 0) return {d[63], 31'd0};
    m = {1'b0, d[51:29]} + {23'd0, (d[28] && ((d[27:0] != 0) || d[29]))};
    if (m[23]) begin e = e + 1; m = 24'd0; end
    return {d[63], e[7:0], m[22:0]};
  endfunction

  function automatic int ulpDiff(input logic [31:0] a, input logic [31:0] b);
    int ia, ib;
    ia = int'(a[30:0]);
    ib = int'(b[30:0]);
    if (a[31] == b[31]) return (ia > ib) ? ia - ib : ib - ia;
    return ia + ib;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%08h expected=%08h", tag, got, exp);
    end
  endtask

  // driver: push expectations, then hand the operand over
  task automatic send(input logic [31:0] x, input string tag);
    bit special, recip, fire;
    special = (&x[30:23]) || (x[30:0] == 31'd0);
    recip   = (!x[31] && x[30:0] > 31'h3F800000) || (x[31] && x[30:0] >= 31'h3F800000);
    if (&x[30:23] && |x[22:0]) begin
      expVal.push_back(x | 32'h00400000); expExact.push_back(1'b1);
    end else if (&x[30:23]) begin
      expVal.push_back({x[31], 31'h3FC90FDB}); expExact.push_back(1'b1);
    end else if (x[30:0] == 31'd0) begin
      expVal.push_back(x); expExact.push_back(1'b1);
    end else begin
      expVal.push_back(toF32($atan(fromF32(x))));
      expExact.push_back(!recip);
      reqArgQ.push_back(x); reqRecipQ.push_back(recip); reqTagQ.push_back(tag);
    end
    expTag.push_back(tag);
    if (special) ; // no core request expected
    @(posedge clk); #1;
    inValid = 1'b1; inX = x;
    forever begin
      @(negedge clk); fire = inReady;
      @(posedge clk);
      if (fire) break;
    end
    #1 inValid = 1'b0;
  endtask

  // core model: random request ready, random latency, in order
  initial begin
    bit taken = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (taken) begin
        void'(coreRes.pop_front()); void'(coreDly.pop_front());
        coreRspValid = 1'b0; taken = 1'b0;
      end
      if (coreDly.size() > 0 && coreDly[0] > 0) coreDly[0] = coreDly[0] - 1;
      if (!coreRspValid && coreRes.size() > 0 && coreDly[0] == 0) begin
        coreRspValid = 1'b1; coreRspData = coreRes[0];
      end
      coreReqReady = rstN && (($urandom % 4) != 0);
      @(negedge clk);
      if (coreReqValid && coreReqReady) begin
        if (reqArgQ.size() == 0) begin
          check(1'b0, "R2 R3 R4 unexpected core request", coreReqArg, 32'h0);
        end else begin
          logic [31:0] ea; bit er; string et; real xr;
          ea = reqArgQ.pop_front(); er = reqRecipQ.pop_front(); et = reqTagQ.pop_front();
          check(coreReqArg == ea && coreReqRecip == er, {et, " core request"},
                {coreReqRecip, coreReqArg[30:0]}, {er, ea[30:0]});
          xr = fromF32(coreReqArg);
          coreRes.push_back(toF32(coreReqRecip ? $atan(1.0 / xr) : $atan(xr)));
          coreDly.push_back($urandom % 7);
        end
      end
      if (coreRspValid && coreRspReady) taken = 1'b1;
    end
  end

  // monitor: pop and compare in order
  initial begin
    forever begin
      @(posedge clk); #1;
      outReady = !holdOut && rstN && (($urandom % 3) != 0);
      @(negedge clk);
      if (outValid && outReady) begin
        if (expVal.size() == 0) begin
          check(1'b0, "R8 unexpected result", outAngle, 32'h0);
        end else begin
          logic [31:0] ev; bit ex; string et;
          ev = expVal.pop_front(); ex = expExact.pop_front(); et = expTag.pop_front();
          if (ex) check(outAngle == ev, et, outAngle, ev);
          else    check(ulpDiff(outAngle, ev) <= TOL_ULP, {et, " R10 ulp"}, outAngle, ev);
          if (monoOn) monoLog.push_back(outAngle);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic drain();
    while (expVal.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0 && coreReqValid == 1'b0 && inReady == 1'b1, "R1 reset",
          {29'd0, outValid, coreReqValid, inReady}, 32'h1);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R2: NaNs quieted, sign and payload kept
    send(32'h7F800001, "R2");
    send(32'hFF812345, "R2");
    send(32'h7FC00000, "R2");
    // R3: infinities
    send(32'h7F800000, "R3");
    send(32'hFF800000, "R3");
    // R4: signed zeros
    send(32'h00000000, "R4");
    send(32'h80000000, "R4");
    // R5: direct path including +1.0 and a subnormal
    send(32'h3F000000, "R5");
    send(32'hBF000000, "R5");
    send(32'h3F800000, "R5");
    send(32'hBF7FFFFF, "R5");
    send(32'h00000005, "R5");
    // R6: positive reduced path
    send(32'h40000000, "R6");
    send(32'h3F800001, "R6");
    send(32'h501502F9, "R6");
    send(32'h7F7FFFFF, "R6");
    // R7: negative reduced path including -1.0
    send(32'hBF800000, "R7");
    send(32'hC0000000, "R7");
    send(32'hD01502F9, "R7");
    send(32'hFF7FFFFF, "R7");
    drain();

    // R8, R10: random mix with specials interleaved
    for (int i = 0; i < 300; i++) begin
      if (i % 7 == 3)
        send((i % 2 == 0) ? 32'hFF800000 : 32'h80000000, "R8");
      else
        send({1'($urandom), 8'(100 + ($urandom % 55)), 23'($urandom)}, "R8");
    end
    drain();

    // R10: monotonic sweeps across -1.0 and +1.0 in ascending value
    monoOn = 1'b1;
    for (int k = 4; k >= -4; k--) send(32'hBF800000 + 32'(k), "R10");
    for (int k = -4; k <= 4; k++) send(32'h3F800000 + 32'(k), "R10");
    drain();
    monoOn = 1'b0;
    for (int i = 1; i < monoLog.size(); i++) begin
      if (i == 9) continue;   // gap between the two sweeps
      check(fromF32(monoLog[i]) >= fromF32(monoLog[i-1]), "R10 monotonic",
            monoLog[i], monoLog[i-1]);
    end

    // R9: back-pressure once DEPTH results are held
    holdOut = 1'b1;
    for (int i = 0; i < DEPTH; i++) send(32'h80000000, "R9");
    @(posedge clk); #1 inX = 32'h00000000;
    @(negedge clk);
    check(inReady == 1'b0, "R9 full", {31'd0, inReady}, 32'h0);
    holdOut = 1'b0;
    send(32'h00000000, "R9");
    drain();

    // R5 R6 R7: every expected core request was issued
    check(reqArgQ.size() == 0, "R5 missing core request", 32'(reqArgQ.size()), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule